// File: doc/BRIEF.md
# SPI Command Frame Receiver

A slave-side serial receiver for a digital potentiometer controller. It accepts 16-bit command words on a serial data input while an active-low select is asserted, in either SPI mode 0 (clock idle low) or mode 3 (clock idle high). Incoming data is sampled on rising clock edges and is taken MSB first. When the select is released, the receiver checks how many bits arrived. If the frame is valid, it splits the last 16 bits into an operation code, an address and a data byte, and it gives a downstream command processor a single-cycle strobe.

All serial pins pass through two-flop synchronizers into the system clock, and edge detection takes place in that domain. Each frame pushes the earlier register contents out on the serial output, so several receivers can share one select line in a daisy chain. Two readback operations reload the shift register from a word supplied by the command processor, and that word then shifts out during the following frame. A select pulse with no clock edges repeats the last command. Frames of the wrong length are rejected.

Top module: `spi_cmd_rx`

## Requirements
- R1: A frame of exactly 16 bits, sent MSB first, is decoded with the operation in bits 15:12, the address in bits 11:8 and the data in bits 7:0. It produces one `cmd_stb` pulse, one system clock long, with `cmd_rpt`=0. The fields hold their values until the next strobe.
- R2: No strobe is issued while select is low. Decoding happens only after select is released.
- R3: A frame whose bit count is a nonzero multiple of 16 (for example 32) decodes only the last 16 bits shifted in.
- R4: When the bit count at release is not a multiple of 4 (for example 15 or 17), no strobe is issued and the shift register is cleared. The next frame then shifts out all zeros.
- R5: When the bit count is a multiple of 4 but not of 16 (for example 20), no strobe is issued and the shift register keeps its contents. The next frame shifts out the last 16 bits received.
- R6: A select pulse with no clock edges re-issues the last decoded command with `cmd_rpt`=1 and unchanged fields. Before any command has been decoded after reset, such a pulse does nothing.
- R7: Operation code 0 is a no-operation. It produces no strobe, leaves the fields as they were, and does not replace the command that a later pulse repeats.
- R8: After a strobe with operation code 9 or 10, `rb_word` is loaded into the shift register and shifts out MSB first in the next frame.
- R9: Every bit shifted in appears on `sdo` 16 clock periods later. The first 16 output bits of a frame are the register contents held before the frame began. `sdo` changes only after a falling clock edge or a select fall.
- R10: `sdo_oe` is 1 while select is low and 0 while it is high.
- R11: Mode 3 framing (clock idle high, data sampled on the rising edge) decodes and shifts out the same way as mode 0.
- R12: After reset, `cmd_stb`, `cmd_rpt` and `sdo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the open-drain driver of `sdo` |
| rb_word | input | 16 | Readback word from the command processor |
| cmd_stb | output | 1 | One-cycle decoded-command strobe |
| cmd_rpt | output | 1 | Strobe is a repeat of the previous command |
| cmd_op | output | 4 | Operation code |
| cmd_adr | output | 4 | Address field |
| cmd_dat | output | 8 | Data field |

## Verification
The bench goes after frame lengths of 15, 17, 20 and 32 bits. A receiver that decoded any 16 bits without checking the length would strobe on the 15-, 17- and 20-bit frames. One that always cleared or always kept the register would shift out the wrong word in the frame after a 15-bit or 20-bit frame. The bench sends clockless select pulses right after reset, after a no-operation, and in mode 3, and compares the repeat flag with the fields. A design that let a no-operation overwrite the stored command would repeat the wrong fields. The bench also compares `sdo` bit by bit across a 32-bit chained frame and across the frames after the two readback operations, which exposes an off-by-one delay or a missed reload.

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int WORD_W = 16,
  parameter int OP_W   = 4,
  parameter int ADR_W  = 4,
  parameter int DAT_W  = 8,
  parameter int SYNC_N = 2,
  parameter int GRAIN  = 4,
  parameter logic [OP_W-1:0] OP_NOP  = 4'd0,
  parameter logic [OP_W-1:0] OP_RB_A = 4'd9,
  parameter logic [OP_W-1:0] OP_RB_B = 4'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [WORD_W-1:0] rb_word,
  output logic              cmd_stb,
  output logic              cmd_rpt,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADR_W-1:0]  cmd_adr,
  output logic [DAT_W-1:0]  cmd_dat
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int G_W   = $clog2(GRAIN);

  logic [SYNC_N-1:0] sck_sy, cs_sy, sdi_sy;
  logic              sck_d, cs_d;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              seen, have, rb_pend, sdo_q;

  wire sck_s = sck_sy[SYNC_N-1];
  wire cs_s  = cs_sy[SYNC_N-1];
  wire sdi_s = sdi_sy[SYNC_N-1];

  wire sck_rise = ~cs_s & sck_s & ~sck_d;
  wire sck_fall = ~cs_s & ~sck_s & sck_d;
  wire cs_fall  = ~cs_s & cs_d;
  wire cs_rise  = cs_s & ~cs_d;

  wire [OP_W-1:0]  op_in  = sr[WORD_W-1 -: OP_W];
  wire [ADR_W-1:0] adr_in = sr[WORD_W-OP_W-1 -: ADR_W];
  wire [DAT_W-1:0] dat_in = sr[DAT_W-1:0];

  function automatic logic is_rb(input logic [OP_W-1:0] op);
    return (op == OP_RB_A) || (op == OP_RB_B);
  endfunction

  assign sdo    = sdo_q;
  assign sdo_oe = ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      sdi_sy  <= '0;
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
      sr      <= '0;
      cnt     <= '0;
      seen    <= 1'b0;
      have    <= 1'b0;
      rb_pend <= 1'b0;
      sdo_q   <= 1'b0;
      cmd_stb <= 1'b0;
      cmd_rpt <= 1'b0;
      cmd_op  <= '0;
      cmd_adr <= '0;
      cmd_dat <= '0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_N-2:0], spi_sck};
      cs_sy   <= {cs_sy[SYNC_N-2:0], spi_cs_n};
      sdi_sy  <= {sdi_sy[SYNC_N-2:0], spi_sdi};
      sck_d   <= sck_s;
      cs_d    <= cs_s;
      cmd_stb <= 1'b0;
      rb_pend <= 1'b0;
      if (rb_pend) sr <= rb_word;
      if (cs_fall) begin
        sdo_q <= sr[WORD_W-1];
        cnt   <= '0;
        seen  <= 1'b0;
      end else if (sck_rise) begin
        sr   <= {sr[WORD_W-2:0], sdi_s};
        cnt  <= cnt + 1'b1;
        seen <= 1'b1;
      end else if (sck_fall) begin
        sdo_q <= sr[WORD_W-1];
      end else if (cs_rise) begin
        if (!seen) begin
          if (have) begin
            cmd_stb <= 1'b1;
            cmd_rpt <= 1'b1;
            rb_pend <= is_rb(cmd_op);
          end
        end else if (cnt == '0) begin
          if (op_in != OP_NOP) begin
            cmd_op  <= op_in;
            cmd_adr <= adr_in;
            cmd_dat <= dat_in;
            cmd_stb <= 1'b1;
            cmd_rpt <= 1'b0;
            have    <= 1'b1;
            rb_pend <= is_rb(op_in);
          end
        end else if (cnt[G_W-1:0] != '0) begin
          sr <= '0;
        end
        cnt  <= '0;
        seen <= 1'b0;
      end
    end
  end

  // R1
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R2
  stb_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> cs_s);

  // R7
  no_nop_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> cmd_op != OP_NOP);

  // R6
  rpt_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_rpt) |-> ($stable(cmd_op) && $stable(cmd_adr) && $stable(cmd_dat)));

  // R9
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sck_fall || cs_fall));
endmodule

// File: tb/sim_spi_cmd_rx.sv
module sim_spi_cmd_rx;
  localparam int CLK_P = 10;
  localparam int H     = 8;

  typedef struct {
    bit          rpt;
    logic [3:0]  op;
    logic [3:0]  adr;
    logic [7:0]  dat;
    string       req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic spi_sck = 0, spi_cs_n = 1, spi_sdi = 0;
  logic sdo, sdo_oe, cmd_stb, cmd_rpt;
  logic [15:0] rb_word = '0;
  logic [3:0] cmd_op, cmd_adr;
  logic [7:0] cmd_dat;

  int n_cmp = 0, n_bad = 0, stb_seen = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_sdi(spi_sdi), .sdo(sdo), .sdo_oe(sdo_oe), .rb_word(rb_word),
    .cmd_stb(cmd_stb), .cmd_rpt(cmd_rpt), .cmd_op(cmd_op),
    .cmd_adr(cmd_adr), .cmd_dat(cmd_dat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit rpt, input logic [15:0] w, input string req);
    exp_t e;
    e.rpt = rpt; e.op = w[15:12]; e.adr = w[11:8]; e.dat = w[7:0]; e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && cmd_stb) begin
      stb_seen++;
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected strobe act=%0h%0h%0h rpt=%0b exp=none",
                 cmd_op, cmd_adr, cmd_dat, cmd_rpt);
      end else begin
        e = q.pop_front();
        if (cmd_rpt !== e.rpt || cmd_op !== e.op || cmd_adr !== e.adr || cmd_dat !== e.dat) begin
          n_bad++;
          $display("FAIL %s act=%0b/%0h%0h%0h exp=%0b/%0h%0h%0h", e.req,
                   cmd_rpt, cmd_op, cmd_adr, cmd_dat, e.rpt, e.op, e.adr, e.dat);
        end
      end
    end
  end

  task automatic frame(input logic [63:0] bits, input int n, input bit m3,
                       output logic [63:0] so);
    int s0;
    so = '0;
    spi_sck = m3;
    repeat (4) @(negedge clk);
    s0 = stb_seen;
    spi_cs_n = 0;
    repeat (H) @(negedge clk);
    chk("R10 oe while selected", sdo_oe, 1);
    for (int i = n - 1; i >= 0; i--) begin
      if (m3) spi_sck = 0;
      spi_sdi = bits[i];
      repeat (H) @(negedge clk);
      so[i] = sdo;
      spi_sck = 1;
      repeat (H) @(negedge clk);
      if (!m3) spi_sck = 0;
    end
    repeat (H) @(negedge clk);
    chk("R2 no strobe before release", stb_seen, s0);
    spi_cs_n = 1;
    repeat (12) @(negedge clk);
    chk("R10 oe released", sdo_oe, 0);
  endtask

  task automatic pulse();
    spi_cs_n = 0;
    repeat (H) @(negedge clk);
    spi_cs_n = 1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    logic [63:0] so;
    int s;
    repeat (5) @(negedge clk);
    chk("R12 strobe after reset", cmd_stb, 0);
    chk("R12 rpt after reset", cmd_rpt, 0);
    chk("R12 oe after reset", sdo_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    pulse();
    chk("R6 no repeat before first command", stb_seen, 0);

    push(0, 16'h35A7, "R1 basic frame");
    frame(64'h35A7, 16, 0, so);
    chk("R1 one strobe", stb_seen, 1);

    push(1, 16'h35A7, "R6 repeat pulse");
    pulse();

    s = stb_seen;
    frame(64'h0012, 16, 0, so);
    chk("R7 nop no strobe", stb_seen, s);
    push(1, 16'h35A7, "R7 repeat skips nop");
    pulse();

    push(0, 16'h2499, "R3 32-bit frame");
    frame(64'h6122_2499, 32, 0, so);
    chk("R9 daisy sdo", so[31:0], 32'h0012_6122);

    rb_word = 16'hBEEF;
    push(0, 16'h9200, "R8 readback 9");
    frame(64'h9200, 16, 0, so);
    push(0, 16'h4110, "R1 frame after readback");
    frame(64'h4110, 16, 0, so);
    chk("R8 readback 9 shifted out", so[15:0], 16'hBEEF);

    rb_word = 16'h1357;
    push(0, 16'hA300, "R8 readback 10");
    frame(64'hA300, 16, 0, so);
    s = stb_seen;
    frame(64'h00F0, 16, 0, so);
    chk("R8 readback 10 shifted out", so[15:0], 16'h1357);
    chk("R7 nop no strobe", stb_seen, s);

    push(0, 16'h76C3, "R11 mode 3 frame");
    frame(64'h76C3, 16, 1, so);
    chk("R11 mode 3 sdo", so[15:0], 16'h00F0);

    s = stb_seen;
    frame(64'h7FFF, 15, 0, so);
    chk("R4 15-bit no strobe", stb_seen, s);
    push(0, 16'h5555, "R4 frame after 15-bit");
    frame(64'h5555, 16, 0, so);
    chk("R4 register cleared", so[15:0], 16'h0000);

    s = stb_seen;
    frame(64'h1FFFF, 17, 0, so);
    chk("R4 17-bit no strobe", stb_seen, s);
    frame(64'hABCDE, 20, 0, so);
    chk("R5 20-bit no strobe", stb_seen, s);
    chk("R4 17-bit cleared register", so[19:4], 16'h0000);
    push(0, 16'h8801, "R5 frame after 20-bit");
    frame(64'h8801, 16, 0, so);
    chk("R5 register kept", so[15:0], 16'hBCDE);

    spi_sck = 1;
    repeat (4) @(negedge clk);
    push(1, 16'h8801, "R6 repeat in mode 3");
    pulse();

    repeat (10) @(negedge clk);
    chk("R1 all expected strobes seen", q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule